// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block turns a 164-bit display image into the drive codes for a 1/4-duty multiplexed LCD panel with four common lines and 41 segment lines. Each output pin carries a 2-bit level code and not an analog voltage. An analog stage outside the block maps the code to ground, the lower middle rail, the upper middle rail or the supply. The block steps through the four commons, one after another, on a base-clock tick. Each common phase has two halves, and the second half inverts every level so that the panel sees no net DC.

Control inputs come from a separate serial front end. They choose 1/3 or 1/2 bias and can blank all segments. They can also put the block to sleep, which drives the panel to ground and restarts the frame. Four of the segment pins can be handed over to general-purpose port outputs. The last two segment pins can be handed over to key-scan drive lines that come from an external key scanner. Reset forces every pin low, and the display image is left untouched.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `rst_n` is low, every code on `seg_lvl` and `com_lvl` is 00, whatever the port, key or display settings are. After release, the pins again follow the unchanged `disp` contents.
- R2: After reset, common 0 is the active common. One half period is `HALF_TICKS` tick pulses. Each common is active for two half periods, polarity 0 first and then polarity 1, and the commons run in the order 0,1,2,3,0. Cycles with `tick` low do not advance the sequence.
- R3: With `bias_half`=0, the active common drives 11 in polarity 0 and 00 in polarity 1. An inactive common drives 01 in polarity 0 and 10 in polarity 1 (codes: 00 ground, 01 lower middle, 10 upper middle, 11 supply).
- R4: With `bias_half`=0, a lit segment drives 00 in polarity 0 and 11 in polarity 1. An unlit segment drives 10 in polarity 0 and 01 in polarity 1.
- R5: With `bias_half`=1, an inactive common drives 01. The active common behaves as in R3. A lit segment behaves as in R4, and an unlit segment drives 11 in polarity 0 and 00 in polarity 1.
- R6: With `seg_off`=1, every pin that works as a segment drives the unlit code for the current bias and polarity.
- R7: With `sleep`=1, all common codes are 00, and every pin that works as a segment drives 00. When sleep ends, the frame restarts at common 0, polarity 0.
- R8: `port_mode` gives the number of port pins, counted from segment 0: 0 gives none, 1 gives one, 2 gives two and 3 gives four. Port pin i drives 11 if `disp[4*i]` is 1 and 00 otherwise. Bias, `seg_off` and `sleep` have no effect on port pins.
- R9: Segment 39 is a key pin when `key_mode`=00. Segment 40 is a key pin when `key_mode[1]`=0. Key pin 39 drives `ks_drive[0]` and key pin 40 drives `ks_drive[1]`, each as 11 or 00, also during sleep.
- R10: Segment n is lit during common k when `disp[4*n+k]` is 1 (n from 0, k from 0). Segment n's code sits at `seg_lvl[2*n+1:2*n]` and common k's code at `com_lvl[2*k+1:2*k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces all codes low |
| tick | input | 1 | Base-clock pulse that advances the frame |
| disp | input | 4*NSEG | Display image, four bits per segment |
| bias_half | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| seg_off | input | 1 | Blanks all segment-function pins |
| sleep | input | 1 | Drives the panel to ground and holds the frame at its start |
| port_mode | input | 2 | Number of low segment pins used as ports |
| key_mode | input | 2 | Hands the top two segment pins to key-scan drive |
| ks_drive | input | 2 | Key-scan drive values for the two shared pins |
| seg_lvl | output | 2*NSEG | Level codes of the segment pins |
| com_lvl | output | 8 | Level codes of the common pins |

## Verification
A fault in the phase counter or the polarity bit shows up as a shifted common pattern. Either the wrong common sits at an extreme code, or all lines sit at the wrong polarity. This is visible right after the next tick pulse and no later than one half period away. A fault in the pin-function selection or the override order shows on the affected pin in the same cycle as the control change, because the codes are decoded combinationally from the registered frame position.

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NSEG       = 41,
  parameter int HALF_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [4*NSEG-1:0] disp,
  input  logic              bias_half,
  input  logic              seg_off,
  input  logic              sleep,
  input  logic [1:0]        port_mode,
  input  logic [1:0]        key_mode,
  input  logic [1:0]        ks_drive,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic [7:0]        com_lvl
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_TICKS - 1);
  localparam logic [1:0] LGND = 2'b00, LLO = 2'b01, LHI = 2'b10, LVDD = 2'b11;

  logic [CW-1:0] cnt;
  logic          pol;
  logic [1:0]    act;
  logic          wrap, dark;
  logic [2:0]    nports;
  logic [1:0]    com_sel, com_idle, seg_on, seg_dim;

  assign wrap = tick && (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      cnt <= '0;
      pol <= 1'b0;
      act <= 2'd0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        pol <= ~pol;
        if (pol) act <= act + 2'd1;
      end
    end
  end

  assign dark     = !rst_n || sleep;
  assign nports   = (port_mode == 2'd3) ? 3'd4 : {1'b0, port_mode};
  assign com_sel  = pol ? LGND : LVDD;
  assign com_idle = bias_half ? LLO : (pol ? LHI : LLO);
  assign seg_on   = pol ? LVDD : LGND;
  assign seg_dim  = bias_half ? (pol ? LGND : LVDD) : (pol ? LLO : LHI);

  for (genvar k = 0; k < 4; k++) begin : g_com
    assign com_lvl[2*k +: 2] = dark ? LGND : ((act == 2'(k)) ? com_sel : com_idle);
  end

  for (genvar n = 0; n < NSEG; n++) begin : g_seg
    logic [3:0] nib;
    logic       lit;
    logic [1:0] code;
    assign nib  = disp[4*n +: 4];
    assign lit  = nib[act] && !seg_off;
    assign code = sleep ? LGND : (lit ? seg_on : seg_dim);
    if (n < 4) begin : g_port
      logic is_port;
      assign is_port = (3'(n) < nports);
      assign seg_lvl[2*n +: 2] = !rst_n ? LGND : (is_port ? {2{nib[0]}} : code);
    end else if (n >= NSEG - 2) begin : g_key
      logic is_key;
      assign is_key = (n == NSEG - 2) ? (key_mode == 2'b00) : !key_mode[1];
      assign seg_lvl[2*n +: 2] = !rst_n ? LGND : (is_key ? {2{ks_drive[n-(NSEG-2)]}} : code);
    end else begin : g_plain
      assign seg_lvl[2*n +: 2] = !rst_n ? LGND : code;
    end
  end
endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
  parameter int NSEG = 41
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [4*NSEG-1:0] disp,
  input logic              bias_half,
  input logic              sleep,
  input logic [1:0]        port_mode,
  input logic [1:0]        key_mode,
  input logic [1:0]        ks_drive,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [7:0]        com_lvl
);
  logic [3:0] ext;
  always_comb begin
    for (int k = 0; k < 4; k++)
      ext[k] = (com_lvl[2*k +: 2] == 2'b00) || (com_lvl[2*k +: 2] == 2'b11);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (seg_lvl == '0 && com_lvl == '0);
    end
  end

  p_one_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> $countones(ext) == 1);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sleep) |=> (sleep || !$stable(bias_half) || $stable(com_lvl)));

  p_sleep_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> com_lvl == 8'h00);

  p_port_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_mode != 2'b00) |-> seg_lvl[1:0] == {2{disp[0]}});

  p_key_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_mode == 2'b00) |-> seg_lvl[2*(NSEG-2) +: 2] == {2{ks_drive[0]}});
endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .disp(disp), .bias_half(bias_half),
  .sleep(sleep), .port_mode(port_mode), .key_mode(key_mode), .ks_drive(ks_drive),
  .seg_lvl(seg_lvl), .com_lvl(com_lvl)
);

// File: tb/tb_lcd_mux_driver.sv
`timescale 1ns/1ps
module tb_lcd_mux_driver;
  localparam int NSEG = 41;
  localparam int HALF = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [4*NSEG-1:0] disp = '0;
  logic              bias_half = 1'b0, seg_off = 1'b0, sleep = 1'b0;
  logic [1:0]        port_mode = 2'b00, key_mode = 2'b10, ks_drive = 2'b00;
  logic [2*NSEG-1:0] seg_lvl;
  logic [7:0]        com_lvl;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_pol = 0, m_act = 0;

  always #2 clk = ~clk;

  lcd_mux_driver #(.NSEG(NSEG), .HALF_TICKS(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .disp(disp), .bias_half(bias_half),
    .seg_off(seg_off), .sleep(sleep), .port_mode(port_mode), .key_mode(key_mode),
    .ks_drive(ks_drive), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
  );

  // fields: bias, off, sleep, port_mode[2], key_mode[2], ks[2], pattern[2]
  localparam logic [10:0] VEC [10] = '{
    {1'b0,1'b0,1'b0,2'd0,2'd2,2'd0,2'd2},
    {1'b0,1'b0,1'b0,2'd0,2'd2,2'd0,2'd1},
    {1'b1,1'b0,1'b0,2'd0,2'd2,2'd0,2'd2},
    {1'b1,1'b0,1'b0,2'd0,2'd2,2'd0,2'd0},
    {1'b0,1'b1,1'b0,2'd0,2'd2,2'd0,2'd2},
    {1'b1,1'b1,1'b0,2'd3,2'd2,2'd0,2'd3},
    {1'b0,1'b0,1'b0,2'd1,2'd0,2'd3,2'd2},
    {1'b0,1'b0,1'b0,2'd2,2'd1,2'd2,2'd3},
    {1'b0,1'b0,1'b1,2'd3,2'd0,2'd1,2'd2},
    {1'b1,1'b0,1'b0,2'd3,2'd3,2'd3,2'd2}
  };
  localparam string TAG [10] = '{
    "R3 R4 R10", "R3 R4", "R5 R10", "R5", "R6", "R6 R8",
    "R8 R9", "R8 R9", "R7 R8 R9", "R2 R7 R8"
  };

  function automatic logic [4*NSEG-1:0] pattern(input logic [1:0] sel);
    logic [4*NSEG-1:0] p;
    for (int i = 0; i < 4*NSEG; i++)
      case (sel)
        2'd0: p[i] = 1'b0;
        2'd1: p[i] = 1'b1;
        2'd2: p[i] = ((i * 5) % 7) < 3;
        default: p[i] = (i % 3) == 0;
      endcase
    return p;
  endfunction

  function automatic logic [7:0] exp_com();
    logic [7:0] e;
    for (int k = 0; k < 4; k++) begin
      if (!rst_n || sleep) e[2*k +: 2] = 2'b00;
      else if (k == m_act) e[2*k +: 2] = m_pol ? 2'b00 : 2'b11;
      else if (bias_half) e[2*k +: 2] = 2'b01;
      else e[2*k +: 2] = m_pol ? 2'b10 : 2'b01;
    end
    return e;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg();
    logic [2*NSEG-1:0] e;
    int np;
    np = (port_mode == 2'd3) ? 4 : int'(port_mode);
    for (int n = 0; n < NSEG; n++) begin
      if (!rst_n) e[2*n +: 2] = 2'b00;
      else if (n < np) e[2*n +: 2] = {2{disp[4*n]}};
      else if (n == NSEG-2 && key_mode == 2'b00) e[2*n +: 2] = {2{ks_drive[0]}};
      else if (n == NSEG-1 && !key_mode[1]) e[2*n +: 2] = {2{ks_drive[1]}};
      else if (sleep) e[2*n +: 2] = 2'b00;
      else if (disp[4*n + m_act] && !seg_off) e[2*n +: 2] = m_pol ? 2'b11 : 2'b00;
      else if (bias_half) e[2*n +: 2] = m_pol ? 2'b00 : 2'b11;
      else e[2*n +: 2] = m_pol ? 2'b01 : 2'b10;
    end
    return e;
  endfunction

  task automatic check(input string tag);
    logic [7:0] ec;
    logic [2*NSEG-1:0] es;
    #1;
    ec = exp_com();
    es = exp_seg();
    n_chk++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      n_bad++;
      $display("FAIL %s: com actual=%h expected=%h seg actual=%h expected=%h",
               tag, com_lvl, ec, seg_lvl, es);
    end
  endtask

  task automatic clr_model();
    m_cnt = 0; m_pol = 0; m_act = 0;
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (rst_n && !sleep) begin
      m_cnt++;
      if (m_cnt == HALF) begin
        m_cnt = 0;
        if (m_pol == 1) begin m_pol = 0; m_act = (m_act + 1) % 4; end
        else m_pol = 1;
      end
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset forces everything low, even with ports and key pins enabled
    disp = pattern(2'd1); port_mode = 2'd3; key_mode = 2'b00; ks_drive = 2'b11;
    repeat (3) @(negedge clk);
    check("R1");
    @(negedge clk) rst_n = 1'b1;
    clr_model();
    check("R1 R2");
    port_mode = 2'd0; key_mode = 2'b10; ks_drive = 2'b00; disp = pattern(2'd2);
    check("R2 R10");

    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      {bias_half, seg_off, sleep, port_mode, key_mode, ks_drive} = VEC[v][10:2];
      disp = pattern(VEC[v][1:0]);
      if (sleep) begin @(negedge clk); clr_model(); end
      check(TAG[v]);
      for (int h = 0; h < 8; h++) begin
        for (int t = 0; t < HALF; t++) begin
          pulse();
          @(negedge clk);
        end
        check(TAG[v]);
      end
    end

    // R2: idle cycles without tick do not advance
    pulse(); pulse();
    repeat (10) @(negedge clk);
    check("R2");

    // R7: sleep in mid-frame, then wake restarts at common 0, polarity 0
    sleep = 1'b1;
    @(negedge clk);
    clr_model();
    check("R7");
    sleep = 1'b0;
    @(negedge clk);
    check("R7");
    repeat (HALF) pulse();
    check("R2 R7");

    // R1: mid-run reset, display image untouched afterwards
    repeat (3) pulse();
    rst_n = 1'b0;
    @(negedge clk);
    clr_model();
    check("R1");
    rst_n = 1'b1;
    check("R1");
    repeat (2*HALF) pulse();
    check("R1 R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule